// File: doc/BRIEF.md
# BCD Seven-Segment Decoder with Blanking Controls

This block converts one binary-coded decimal digit into the seven segment drive lines of a common-anode numeric display. The segment outputs are active low, so a line driven to 0 lights its segment. Three control inputs sit on top of the plain lookup: a lamp-test input that lights every segment, a blanking input that darkens the digit, and a ripple-blanking input/output pair.

The ripple pair suppresses leading zeros across a row of digits. Each digit's ripple output feeds the ripple input of the next lower digit. The most significant digit has its ripple input tied low. The least significant digit has its ripple input tied high, so a value of zero still shows one `0`. The decoder is purely combinational.

Top module: `seg7_bcd_decoder`

## Requirements
- R1: For data codes 0 to 9, with every control inactive, `seg_n` shows the numeral. Bit 0 is segment a (top), then b (upper right), c (lower right), d (bottom), e (lower left), f (upper left), and bit 6 is g (middle). The lit sets are: 0=abcdef, 1=bc, 2=abdeg, 3=abcdg, 4=bcfg, 5=acdfg, 6=acdefg, 7=abc, 8=all seven, 9=abcdfg.
- R2: Segment outputs are active low: 0 means lit and 1 means dark. `bcd_in[0]` is the least significant data bit.
- R3: While `lamp_test_n` is 0, all seven outputs are 0, whatever the data and the other controls are.
- R4: While `lamp_test_n` is 1 and `blank_n` is 0, all seven outputs are 1.
- R5: While `lamp_test_n` is 1, `ripple_in_n` is 0 and the data code is 0000, all seven outputs are 1. This holds whatever the state of `blank_n`.
- R6: `ripple_out_n` is 0 exactly when `lamp_test_n` is 1, `ripple_in_n` is 0 and the code is 0000. In every other case it is 1.
- R7: With lamp test inactive, data codes 1010 to 1111 drive all outputs to 1. A low `ripple_in_n` with a nonzero code has no effect on the digit shown.
- R8: In a chain of digits wired as described above, leading zero digits are dark, zeros after the first nonzero digit are shown, and an all-zero value shows a single `0` in the least significant place.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| bcd_in | input | 4 | BCD digit, bit 0 least significant |
| lamp_test_n | input | 1 | Lamp test, active low; lights all segments |
| blank_n | input | 1 | Forced blanking, active low |
| ripple_in_n | input | 1 | Ripple-blank input, active low; blanks a zero digit |
| seg_n | output | 7 | Segment drives a..g on bits 0..6, active low |
| ripple_out_n | output | 1 | Ripple-blank output, low when this digit was zero-suppressed |

## Verification
Assertions check the control overrides every time the inputs change. These cover: lamp test lights everything, forced blanking and ripple blanking darken the digit, codes above nine stay dark, and the ripple output falls only for a suppressed zero. Assertions cannot show that each numeral has the correct segment shape, because that needs an independent table. The bench therefore sweeps all sixteen codes against all eight control combinations and compares the result with segment masks it builds itself. Leading-zero suppression across several digits only appears when digits are cascaded, so the bench checks it on a four-digit chain with chosen values.

// File: rtl/seg7_pkg.sv
package seg7_pkg;
  localparam int BCD_W = 4;
  localparam int SEG_W = 7;
  localparam int MAX_DIGIT = 9;

  typedef logic [BCD_W-1:0] bcd_t;
  typedef logic [SEG_W-1:0] seg_t;

  typedef enum logic [1:0] {
    SHOW_GLYPH = 2'd0,
    SHOW_DARK  = 2'd1,
    SHOW_LAMP  = 2'd2
  } show_e;

  // Active-high lit pattern; bit 0 = a (top) ... bit 6 = g (middle).
  function automatic seg_t glyph_lit(input bcd_t code);
    seg_t pat;
    case (code)
      4'd0: pat = 7'h3F;
      4'd1: pat = 7'h06;
      4'd2: pat = 7'h5B;
      4'd3: pat = 7'h4F;
      4'd4: pat = 7'h66;
      4'd5: pat = 7'h6D;
      4'd6: pat = 7'h7D;
      4'd7: pat = 7'h07;
      4'd8: pat = 7'h7F;
      4'd9: pat = 7'h6F;
      default: pat = '0;
    endcase
    return pat;
  endfunction

  function automatic logic code_in_range(input bcd_t code);
    return (int'(code) <= MAX_DIGIT);
  endfunction

  function automatic logic code_is_zero(input bcd_t code);
    return (code == '0);
  endfunction
endpackage

// File: rtl/seg7_glyph.sv
module seg7_glyph
  import seg7_pkg::*;
(
  input  bcd_t bcd,
  output seg_t lit,
  output logic in_range,
  output logic is_zero
);
  always_comb begin
    lit      = glyph_lit(bcd);
    in_range = code_in_range(bcd);
    is_zero  = code_is_zero(bcd);
  end
endmodule

// File: rtl/seg7_priority.sv
module seg7_priority
  import seg7_pkg::*;
(
  input  logic  lamp_test_n,
  input  logic  blank_n,
  input  logic  ripple_in_n,
  input  logic  digit_zero,
  input  logic  digit_valid,
  output show_e mode,
  output logic  ripple_out_n,
  output logic  lamp_evt,
  output logic  force_dark_evt,
  output logic  ripple_evt
);
  always_comb begin
    lamp_evt       = ~lamp_test_n;
    force_dark_evt = lamp_test_n & ~blank_n;
    ripple_evt     = lamp_test_n & ~ripple_in_n & digit_zero;
    ripple_out_n   = ~ripple_evt;
    if (lamp_evt)
      mode = SHOW_LAMP;
    else if (force_dark_evt || ripple_evt || !digit_valid)
      mode = SHOW_DARK;
    else
      mode = SHOW_GLYPH;
  end
endmodule

// File: rtl/seg7_driver.sv
module seg7_driver
  import seg7_pkg::*;
(
  input  show_e mode,
  input  seg_t  lit,
  output seg_t  seg_n
);
  seg_t on_set;

  always_comb begin
    case (mode)
      SHOW_LAMP:  on_set = '1;
      SHOW_GLYPH: on_set = lit;
      default:    on_set = '0;
    endcase
  end

  for (genvar s = 0; s < SEG_W; s++) begin : g_pin
    assign seg_n[s] = ~on_set[s];
  end
endmodule

// File: rtl/seg7_bcd_decoder.sv
module seg7_bcd_decoder
  import seg7_pkg::*;
(
  input  logic [3:0] bcd_in,
  input  logic       lamp_test_n,
  input  logic       blank_n,
  input  logic       ripple_in_n,
  output logic [6:0] seg_n,
  output logic       ripple_out_n
);
  seg_t  lit;
  logic  in_range;
  logic  is_zero;
  show_e mode;
  logic  lamp_evt;
  logic  force_dark_evt;
  logic  ripple_evt;

  seg7_glyph u_glyph (
    .bcd      (bcd_in),
    .lit      (lit),
    .in_range (in_range),
    .is_zero  (is_zero)
  );

  seg7_priority u_prio (
    .lamp_test_n    (lamp_test_n),
    .blank_n        (blank_n),
    .ripple_in_n    (ripple_in_n),
    .digit_zero     (is_zero),
    .digit_valid    (in_range),
    .mode           (mode),
    .ripple_out_n   (ripple_out_n),
    .lamp_evt       (lamp_evt),
    .force_dark_evt (force_dark_evt),
    .ripple_evt     (ripple_evt)
  );

  seg7_driver u_drv (
    .mode  (mode),
    .lit   (lit),
    .seg_n (seg_n)
  );

  always_comb begin
    // R3
    if (!lamp_test_n)
      lamp_all_on_chk: assert (seg_n == '0)
        else $error("lamp test did not light all segments");
    // R4
    if (lamp_test_n && !blank_n)
      blank_dark_chk: assert (&seg_n)
        else $error("forced blanking left a segment lit");
    // R5
    if (lamp_test_n && !ripple_in_n && bcd_in == 4'd0)
      ripple_dark_chk: assert (&seg_n && !ripple_out_n)
        else $error("ripple-blanked zero not dark");
    // R6
    if (!ripple_out_n)
      ripple_out_cause_chk: assert (lamp_test_n && !ripple_in_n && bcd_in == 4'd0)
        else $error("ripple output low without a suppressed zero");
    // R7
    if (lamp_test_n && !in_range)
      range_dark_chk: assert (&seg_n)
        else $error("out-of-range code lit a segment");
    // R1
    if (mode == SHOW_GLYPH)
      glyph_lit_chk: assert ($countones(~seg_n) >= 2 && !lamp_evt && !force_dark_evt && !ripple_evt)
        else $error("numeral shown with too few segments or under an override");
  end
endmodule

// File: tb/seg7_chain.sv
module seg7_chain #(
  parameter int DIGITS = 4
) (
  input  logic [4*DIGITS-1:0] digits_bcd,
  input  logic                lamp_test_n,
  input  logic                blank_n,
  output logic [7*DIGITS-1:0] seg_n
);
  logic [DIGITS-1:0] rbi_n;
  logic [DIGITS-1:0] rbo_n;

  for (genvar i = 0; i < DIGITS; i++) begin : g_dig
    if (i == DIGITS - 1) begin : g_top
      assign rbi_n[i] = 1'b0;
    end else if (i == 0) begin : g_lsd
      assign rbi_n[i] = 1'b1;
    end else begin : g_mid
      assign rbi_n[i] = rbo_n[i+1];
    end
    seg7_bcd_decoder u_dec (
      .bcd_in       (digits_bcd[4*i +: 4]),
      .lamp_test_n  (lamp_test_n),
      .blank_n      (blank_n),
      .ripple_in_n  (rbi_n[i]),
      .seg_n        (seg_n[7*i +: 7]),
      .ripple_out_n (rbo_n[i])
    );
  end
endmodule

// File: tb/seg7_bcd_decoder_bench.sv
module seg7_bcd_decoder_bench;
  localparam int CLK_PERIOD = 10;
  localparam int NDIG = 4;

  logic clk = 1'b0;
  always #(CLK_PERIOD/2) clk = ~clk;

  logic [3:0] bcd_in;
  logic       lamp_test_n, blank_n, ripple_in_n;
  logic [6:0] seg_n;
  logic       ripple_out_n;

  logic [4*NDIG-1:0] ch_bcd;
  logic              ch_lt_n, ch_bi_n;
  logic [7*NDIG-1:0] ch_seg;

  int checks = 0;
  int errors = 0;
  bit done = 0;

  seg7_bcd_decoder u_seg7_bcd_decoder (
    .bcd_in(bcd_in), .lamp_test_n(lamp_test_n), .blank_n(blank_n),
    .ripple_in_n(ripple_in_n), .seg_n(seg_n), .ripple_out_n(ripple_out_n)
  );

  seg7_chain #(.DIGITS(NDIG)) u_chain (
    .digits_bcd(ch_bcd), .lamp_test_n(ch_lt_n), .blank_n(ch_bi_n), .seg_n(ch_seg)
  );

  // Column masks: bit d set when numeral d lights that segment (a..g).
  function automatic logic [6:0] ref_lit(input int d);
    logic [9:0] m [7];
    logic [6:0] r;
    m[0] = 10'b1111101101; m[1] = 10'b1110011111; m[2] = 10'b1111111011;
    m[3] = 10'b1101101101; m[4] = 10'b0101000101; m[5] = 10'b1101110001;
    m[6] = 10'b1101111100;
    for (int s = 0; s < 7; s++) r[s] = m[s][d];
    return r;
  endfunction

  function automatic logic [6:0] ref_seg(input int code, input bit lt, input bit bi, input bit rbi);
    if (!lt) return 7'h00;
    if (!bi) return 7'h7F;
    if (!rbi && code == 0) return 7'h7F;
    if (code > 9) return 7'h7F;
    return ~ref_lit(code);
  endfunction

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic chain_case(input logic [4*NDIG-1:0] val, input bit lt, input bit bi);
    logic [7*NDIG-1:0] exp;
    bit sup;
    @(posedge clk);
    ch_bcd = val; ch_lt_n = lt; ch_bi_n = bi;
    sup = 1;
    for (int i = NDIG - 1; i >= 0; i--) begin
      int d;
      d = int'(val[4*i +: 4]);
      if (i > 0 && sup && d == 0) exp[7*i +: 7] = lt ? 7'h7F : 7'h00;
      else begin
        sup = 0;
        exp[7*i +: 7] = ref_seg(d, lt, bi, 1'b1);
      end
    end
    @(negedge clk);
    check("R8 chain", 32'(ch_seg), 32'(exp));
  endtask

  initial begin
    bcd_in = 4'd8; lamp_test_n = 1'b1; blank_n = 1'b1; ripple_in_n = 1'b1;
    ch_bcd = '0; ch_lt_n = 1'b1; ch_bi_n = 1'b1;
    @(negedge clk);
    check("R1 R2 initial eight", 32'(seg_n), 32'h00);
    check("R6 initial ripple out", 32'(ripple_out_n), 32'h1);

    // Exhaustive: 16 codes x 8 control combinations (R1..R7)
    for (int c = 0; c < 16; c++) begin
      for (int k = 0; k < 8; k++) begin
        bit lt, bi, rbi;
        lt = k[2]; bi = k[1]; rbi = k[0];
        @(posedge clk);
        bcd_in = 4'(c); lamp_test_n = lt; blank_n = bi; ripple_in_n = rbi;
        @(negedge clk);
        check(!lt ? "R3 lamp" : !bi ? "R4 blank" : (!rbi && c == 0) ? "R5 ripple"
              : (c > 9) ? "R7 range" : "R1 R2 numeral",
              32'(seg_n), 32'(ref_seg(c, lt, bi, rbi)));
        check("R6 ripple out", 32'(ripple_out_n), 32'(!(lt && !rbi && c == 0)));
      end
    end

    // R8 multi-digit leading-zero suppression
    chain_case(16'h0000, 1, 1);
    chain_case(16'h0007, 1, 1);
    chain_case(16'h0042, 1, 1);
    chain_case(16'h0305, 1, 1);
    chain_case(16'h1000, 1, 1);
    chain_case(16'h9999, 1, 1);
    chain_case(16'h0040, 0, 1);
    chain_case(16'h0040, 1, 0);
    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    #(CLK_PERIOD * 20000);
    if (!done) begin
      checks++; errors++;
      $display("FAIL watchdog actual=timeout expected=completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end
endmodule